// File: doc/BRIEF.md
# Issue Interlock Scoreboard

This block sits between decode and execute in an in-order scalar core and decides, each cycle, whether the instruction offered by decode may enter execute. For each architectural register it keeps a small down-counter. The counter is loaded when an instruction that writes the register issues, and it decays by one every cycle. A separate timer tracks how long the execute stage stays occupied by the last instruction, because multi-cycle classes recirculate there.

For every instruction class, the time execute stays occupied and the time until the result can be read are set independently. A short load that is followed at once by a store of the loaded register has a forwarding path that removes one cycle of wait. This applies only when the loaded register supplies the store's data and not its address.

Decode holds its outputs steady while `stall` is high. The instruction enters execute in the cycle in which `issue` is high.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset no register is pending and execute is idle, so a valid instruction with no conflicts issues in the same cycle it is offered. `stall` is low whenever `dec_valid` is low. `issue` equals `dec_valid` and not `stall`.
- R2: An enabled source register that was written by an instruction issued at cycle t stalls the reader until cycle t+L. L is the result latency of the class code. Codes 0 (plain ALU) and 2 (16-bit multiply) have L=1 and L=2. Code 1 (ALU, register shift) has L=2. Code 3 (16-bit multiply-accumulate) has L=2. Codes 4 and 5 (32-bit multiply, plain and flag-setting) have L=3. Codes 6 and 7 (64-bit multiply, plain and flag-setting) have L=4. Code 8 (one- or two-register load) has L=2. Code 9 (three- or four-register load) has L=3.
- R3: An instruction issued at cycle t occupies execute for O cycles, and no instruction of any kind issues before cycle t+O. O is 1 for codes 0, 2, 8 and 10. O is 2 for codes 1, 3 and 4. O is 3 for codes 6 and 9. O is 4 for code 5 and 5 for code 7.
- R4: When both destination enables are set, both destination registers become pending with the same latency, so a reader of either one waits the same time.
- R5: An instruction whose enabled destination register is still pending stalls until that register is free.
- R6: A store (code 10) reads its address from source 0 and its data from source 1. If the instruction issued in the previous cycle was a code-8 load that wrote the data register, the store issues with no wait. If the address register is the load's destination, the store waits the full latency.
- R7: A store marks no register pending, even when its destination enables are set.
- R8: A source or destination whose enable is low is ignored. Register index 0 is tracked like any other register.
- R9: Class codes 11 to 15 behave as a plain ALU operation (L=1, O=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode offers an instruction |
| dec_class | input | 4 | Instruction class code |
| src0_idx | input | 4 | Source 0 register (store address) |
| src0_en | input | 1 | Source 0 used |
| src1_idx | input | 4 | Source 1 register (store data) |
| src1_en | input | 1 | Source 1 used |
| dst0_idx | input | 4 | First destination register |
| dst0_en | input | 1 | First destination written |
| dst1_idx | input | 4 | Second destination register |
| dst1_en | input | 1 | Second destination written |
| stall | output | 1 | Offered instruction must wait |
| issue | output | 1 | Offered instruction enters execute this cycle |

## Verification
The hardest condition to reach from the ports is the load-to-store forwarding case. The store has to be offered in exactly the cycle after the load issues. This must happen while the loaded register is still pending, and the address register must differ from it. The stimulus tasks present each instruction on the falling edge that follows the previous issue, so a producer and its consumer always arrive back to back. A second store variant uses the loaded register as its address, and its expected one-cycle wait shows that the forwarding is not applied too broadly. For the flag-setting multiplies, occupancy is longer than latency. These classes are checked with both a dependent reader and an independent reader, so that the two timers are told apart.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int SB_CNT_W = 3;

  typedef enum logic [3:0] {
    CL_ALU       = 4'd0,
    CL_ALU_SHREG = 4'd1,
    CL_MUL16     = 4'd2,
    CL_MAC16     = 4'd3,
    CL_MUL32     = 4'd4,
    CL_MUL32_FL  = 4'd5,
    CL_MUL64     = 4'd6,
    CL_MUL64_FL  = 4'd7,
    CL_LD_SHORT  = 4'd8,
    CL_LD_MULTI  = 4'd9,
    CL_STORE     = 4'd10
  } iclass_e;

  // Cycles until a dependent may issue.
  function automatic logic [SB_CNT_W-1:0] result_lat(input logic [3:0] c);
    case (c)
      CL_ALU_SHREG, CL_MUL16, CL_MAC16, CL_LD_SHORT: result_lat = 3'd2;
      CL_MUL32, CL_MUL32_FL, CL_LD_MULTI:            result_lat = 3'd3;
      CL_MUL64, CL_MUL64_FL:                         result_lat = 3'd4;
      CL_STORE:                                      result_lat = 3'd0;
      default:                                       result_lat = 3'd1;
    endcase
  endfunction

  // Cycles the execute stage stays occupied.
  function automatic logic [SB_CNT_W-1:0] exec_occ(input logic [3:0] c);
    case (c)
      CL_ALU_SHREG, CL_MAC16, CL_MUL32: exec_occ = 3'd2;
      CL_MUL64, CL_LD_MULTI:            exec_occ = 3'd3;
      CL_MUL32_FL:                      exec_occ = 3'd4;
      CL_MUL64_FL:                      exec_occ = 3'd5;
      default:                          exec_occ = 3'd1;
    endcase
  endfunction

  // Counter load value: remaining wait after the issue cycle.
  function automatic logic [SB_CNT_W-1:0] arm_value(input logic [SB_CNT_W-1:0] cycles);
    arm_value = (cycles == '0) ? '0 : cycles - 1'b1;
  endfunction

endpackage

// File: rtl/sb_reg_timers.sv
module sb_reg_timers #(
  parameter int NREG  = 16,
  parameter int CNT_W = 3,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set0_en,
  input  logic [IDX_W-1:0] set0_idx,
  input  logic             set1_en,
  input  logic [IDX_W-1:0] set1_idx,
  input  logic [CNT_W-1:0] set_val,
  output logic [NREG-1:0]  busy
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [CNT_W-1:0] cnt;
    logic             hit;

    assign hit = (set0_en && (set0_idx == IDX_W'(g))) ||
                 (set1_en && (set1_idx == IDX_W'(g)));

    always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (hit)        cnt <= set_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy[g] = (cnt != '0);
  end

endmodule

// File: rtl/sb_exec_timer.sv
module sb_exec_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)            remain <= '0;
    else if (start)        remain <= load_val;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/sb_hazard.sv
module sb_hazard #(
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  busy,
  input  logic             is_store,
  input  logic [IDX_W-1:0] src0_idx,
  input  logic             src0_en,
  input  logic [IDX_W-1:0] src1_idx,
  input  logic             src1_en,
  input  logic [IDX_W-1:0] dst0_idx,
  input  logic             dst0_en,
  input  logic [IDX_W-1:0] dst1_idx,
  input  logic             dst1_en,
  input  logic             fwd_valid,
  input  logic [IDX_W-1:0] fwd_idx0,
  input  logic             fwd_en0,
  input  logic [IDX_W-1:0] fwd_idx1,
  input  logic             fwd_en1,
  output logic             fwd_waive,
  output logic             raw_hit,
  output logic             waw_hit
);

  logic fwd_match;
  logic raw0, raw1;

  assign fwd_match = (fwd_en0 && (fwd_idx0 == src1_idx)) ||
                     (fwd_en1 && (fwd_idx1 == src1_idx));
  // Only the store-data operand may take the forwarded value.
  assign fwd_waive = is_store && src1_en && fwd_valid && fwd_match;

  assign raw0    = src0_en && busy[src0_idx];
  assign raw1    = src1_en && busy[src1_idx] && !fwd_waive;
  assign raw_hit = raw0 || raw1;

  assign waw_hit = !is_store &&
                   ((dst0_en && busy[dst0_idx]) || (dst1_en && busy[dst1_idx]));

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int CNT_W = sb_pkg::SB_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [3:0]       dec_class,
  input  logic [IDX_W-1:0] src0_idx,
  input  logic             src0_en,
  input  logic [IDX_W-1:0] src1_idx,
  input  logic             src1_en,
  input  logic [IDX_W-1:0] dst0_idx,
  input  logic             dst0_en,
  input  logic [IDX_W-1:0] dst1_idx,
  input  logic             dst1_en,
  output logic             stall,
  output logic             issue
);
  import sb_pkg::*;

  logic [NREG-1:0]  reg_busy;
  logic             ex_busy;
  logic             raw_hit;
  logic             waw_hit;
  logic             fwd_waive;
  logic             is_store;
  logic [CNT_W-1:0] lat_arm;
  logic [CNT_W-1:0] occ_arm;
  logic             mark0, mark1;

  logic             fwd_valid;
  logic [IDX_W-1:0] fwd_idx0, fwd_idx1;
  logic             fwd_en0, fwd_en1;

  assign is_store = (dec_class == CL_STORE);
  assign lat_arm  = arm_value(result_lat(dec_class));
  assign occ_arm  = arm_value(exec_occ(dec_class));

  sb_hazard #(.NREG(NREG)) u_hazard (
    .busy      (reg_busy),
    .is_store  (is_store),
    .src0_idx  (src0_idx),
    .src0_en   (src0_en),
    .src1_idx  (src1_idx),
    .src1_en   (src1_en),
    .dst0_idx  (dst0_idx),
    .dst0_en   (dst0_en),
    .dst1_idx  (dst1_idx),
    .dst1_en   (dst1_en),
    .fwd_valid (fwd_valid),
    .fwd_idx0  (fwd_idx0),
    .fwd_en0   (fwd_en0),
    .fwd_idx1  (fwd_idx1),
    .fwd_en1   (fwd_en1),
    .fwd_waive (fwd_waive),
    .raw_hit   (raw_hit),
    .waw_hit   (waw_hit)
  );

  assign stall = dec_valid && (ex_busy || raw_hit || waw_hit);
  assign issue = dec_valid && !stall;

  assign mark0 = issue && dst0_en && !is_store;
  assign mark1 = issue && dst1_en && !is_store;

  sb_reg_timers #(.NREG(NREG), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .set0_en  (mark0),
    .set0_idx (dst0_idx),
    .set1_en  (mark1),
    .set1_idx (dst1_idx),
    .set_val  (lat_arm),
    .busy     (reg_busy)
  );

  sb_exec_timer #(.CNT_W(CNT_W)) u_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (issue),
    .load_val (occ_arm),
    .busy     (ex_busy)
  );

  // Remember the short load issued last cycle for store-data forwarding.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_en0   <= 1'b0;
      fwd_en1   <= 1'b0;
      fwd_idx0  <= '0;
      fwd_idx1  <= '0;
    end else begin
      fwd_valid <= issue && (dec_class == CL_LD_SHORT);
      fwd_en0   <= dst0_en;
      fwd_en1   <= dst1_en;
      fwd_idx0  <= dst0_idx;
      fwd_idx1  <= dst1_idx;
    end
  end

endmodule

// File: rtl/issue_scoreboard_chk.sv
module issue_scoreboard_chk #(
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic [3:0]       dec_class,
  input logic [IDX_W-1:0] src0_idx,
  input logic             src0_en,
  input logic [IDX_W-1:0] src1_idx,
  input logic             src1_en,
  input logic [IDX_W-1:0] dst0_idx,
  input logic             dst0_en,
  input logic [IDX_W-1:0] dst1_idx,
  input logic             dst1_en,
  input logic             stall,
  input logic             issue,
  input logic             ex_busy,
  input logic             fwd_waive,
  input logic [NREG-1:0]  reg_busy
);

  AST_ISSUE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (dec_valid && !stall)); // R1

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!stall && !issue)); // R1

  AST_EXEC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ex_busy |-> !issue); // R3

  AST_LONG_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_class == 4'd7) |=> ex_busy); // R3

  AST_RAW_SRC0: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && src0_en) |-> !reg_busy[src0_idx]); // R2

  AST_RAW_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && src1_en && !fwd_waive) |-> !reg_busy[src1_idx]); // R2

  AST_WAW_DST0: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dst0_en && dec_class != 4'd10) |-> !reg_busy[dst0_idx]); // R5

  AST_PAIR_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dst0_en && dst1_en && (dec_class == 4'd6 || dec_class == 4'd7))
    |=> (reg_busy[$past(dst0_idx)] && reg_busy[$past(dst1_idx)])); // R4

  AST_STORE_NOMARK: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_class == 4'd10 && dst0_en && !reg_busy[dst0_idx])
    |=> !reg_busy[$past(dst0_idx)]); // R7

endmodule

bind issue_scoreboard issue_scoreboard_chk #(.NREG(NREG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_valid (dec_valid),
  .dec_class (dec_class),
  .src0_idx  (src0_idx),
  .src0_en   (src0_en),
  .src1_idx  (src1_idx),
  .src1_en   (src1_en),
  .dst0_idx  (dst0_idx),
  .dst0_en   (dst0_en),
  .dst1_idx  (dst1_idx),
  .dst1_en   (dst1_en),
  .stall     (stall),
  .issue     (issue),
  .ex_busy   (ex_busy),
  .fwd_waive (fwd_waive),
  .reg_busy  (reg_busy)
);

// File: tb/test_issue_scoreboard.sv
module test_issue_scoreboard;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dec_valid;
  logic [3:0] dec_class;
  logic [3:0] src0_idx, src1_idx, dst0_idx, dst1_idx;
  logic       src0_en, src1_en, dst0_en, dst1_en;
  logic       stall, issue;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  issue_scoreboard i_issue_scoreboard (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
    .src0_idx(src0_idx), .src0_en(src0_en), .src1_idx(src1_idx), .src1_en(src1_en),
    .dst0_idx(dst0_idx), .dst0_en(dst0_en), .dst1_idx(dst1_idx), .dst1_en(dst1_en),
    .stall(stall), .issue(issue)
  );

  // Bench-side restatement of the timing rules, by class code.
  function automatic int lat_of(input int c);
    int t[11] = '{1, 2, 2, 2, 3, 3, 4, 4, 2, 3, 0};
    return (c <= 10) ? t[c] : 1;
  endfunction

  function automatic int occ_of(input int c);
    int t[11] = '{1, 2, 1, 2, 2, 4, 3, 5, 1, 3, 1};
    return (c <= 10) ? t[c] : 1;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Offer one instruction at a falling edge; count stall cycles until issue.
  task automatic send(input int cls, input int s0, input bit s0e, input int s1, input bit s1e,
                      input int d0, input bit d0e, input int d1, input bit d1e,
                      output int waits);
    dec_valid = 1'b1;
    dec_class = 4'(cls);
    src0_idx = 4'(s0); src0_en = s0e;
    src1_idx = 4'(s1); src1_en = s1e;
    dst0_idx = 4'(d0); dst0_en = d0e;
    dst1_idx = 4'(d1); dst1_en = d1e;
    waits = 0;
    forever begin
      #1;
      if (issue || waits > 40) break;
      @(posedge clk); @(negedge clk);
      waits++;
    end
    @(posedge clk); @(negedge clk);
    dec_valid = 1'b0;
    src0_en = 1'b0; src1_en = 1'b0; dst0_en = 1'b0; dst1_en = 1'b0;
  endtask

  task automatic idle(input int n);
    dec_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    int w;
    #1;
    check("R1 stall idle", int'(stall), 0);
    check("R1 issue idle", int'(issue), 0);
    send(0, 1, 1, 2, 1, 3, 1, 0, 0, w);
    check("R1 first issue", w, 0);
    idle(6);
  endtask

  // Producer writes r3, dependent reads it at once via source 0.
  task automatic t_latency;
    int w;
    for (int c = 0; c <= 9; c++) begin
      send(c, 0, 0, 0, 0, 3, 1, 0, 0, w);
      send(0, 3, 1, 0, 0, 11, 1, 0, 0, w);
      check($sformatf("R2 class %0d", c), w, imax(lat_of(c), occ_of(c)) - 1);
      idle(6);
    end
    send(2, 0, 0, 0, 0, 5, 1, 0, 0, w);
    send(0, 0, 0, 5, 1, 11, 1, 0, 0, w);
    check("R2 src1 path", w, 1);
    idle(6);
  endtask

  // Producer then an independent instruction.
  task automatic t_occupancy;
    int w;
    for (int c = 0; c <= 10; c++) begin
      send(c, 0, 0, 0, 0, 3, (c != 10), 0, 0, w);
      send(0, 1, 1, 2, 1, 12, 1, 0, 0, w);
      check($sformatf("R3 class %0d", c), w, occ_of(c) - 1);
      idle(6);
    end
  endtask

  task automatic t_pair;
    int w;
    send(6, 0, 0, 0, 0, 4, 1, 5, 1, w);
    send(0, 5, 1, 0, 0, 11, 1, 0, 0, w);
    check("R4 high word", w, 3);
    idle(6);
    send(7, 0, 0, 0, 0, 4, 1, 5, 1, w);
    send(0, 0, 0, 4, 1, 11, 1, 0, 0, w);
    check("R4 low word flag form", w, 4);
    idle(6);
  endtask

  task automatic t_waw;
    int w;
    send(4, 0, 0, 0, 0, 6, 1, 0, 0, w);
    send(0, 0, 0, 0, 0, 6, 1, 0, 0, w);
    check("R5 dst0 pending", w, 2);
    idle(6);
    send(6, 0, 0, 0, 0, 6, 1, 7, 1, w);
    send(0, 0, 0, 0, 0, 9, 1, 7, 1, w);
    check("R5 dst1 pending", w, 3);
    idle(6);
  endtask

  task automatic t_forward;
    int w;
    send(8, 0, 0, 0, 0, 7, 1, 0, 0, w);
    send(10, 1, 1, 7, 1, 0, 0, 0, 0, w);
    check("R6 store data forwarded", w, 0);
    idle(6);
    send(8, 0, 0, 0, 0, 7, 1, 0, 0, w);
    send(10, 7, 1, 2, 1, 0, 0, 0, 0, w);
    check("R6 store address waits", w, 1);
    idle(6);
    send(8, 0, 0, 0, 0, 6, 1, 7, 1, w);
    send(10, 1, 1, 7, 1, 0, 0, 0, 0, w);
    check("R6 second load word forwarded", w, 0);
    idle(6);
    send(9, 0, 0, 0, 0, 7, 1, 0, 0, w);
    send(10, 1, 1, 7, 1, 0, 0, 0, 0, w);
    check("R6 long load not forwarded", w, 2);
    idle(6);
  endtask

  task automatic t_store_nomark;
    int w;
    send(10, 1, 1, 2, 1, 8, 1, 9, 1, w);
    send(0, 8, 1, 9, 1, 11, 1, 0, 0, w);
    check("R7 store dest unmarked", w, 0);
    idle(6);
  endtask

  task automatic t_enables;
    int w;
    send(2, 0, 0, 0, 0, 0, 1, 0, 0, w);
    send(0, 0, 1, 0, 0, 11, 1, 0, 0, w);
    check("R8 register 0 tracked", w, 1);
    idle(6);
    send(2, 0, 0, 0, 0, 0, 1, 0, 0, w);
    send(0, 0, 0, 0, 0, 11, 1, 0, 0, w);
    check("R8 disabled source ignored", w, 0);
    idle(6);
    send(4, 0, 0, 0, 0, 3, 0, 0, 0, w);
    idle(1);
    send(0, 3, 1, 0, 0, 11, 1, 0, 0, w);
    check("R8 disabled dest unmarked", w, 0);
    idle(6);
  endtask

  task automatic t_unknown;
    int w;
    send(14, 0, 0, 0, 0, 9, 1, 0, 0, w);
    send(0, 9, 1, 0, 0, 11, 1, 0, 0, w);
    check("R9 code 14 as ALU", w, 0);
    idle(6);
  endtask

  initial begin
    rst_n = 1'b0; dec_valid = 1'b0; dec_class = '0;
    src0_idx = '0; src1_idx = '0; dst0_idx = '0; dst1_idx = '0;
    src0_en = 1'b0; src1_en = 1'b0; dst0_en = 1'b0; dst1_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_occupancy();
    t_pair();
    t_waw();
    t_forward();
    t_store_nomark();
    t_enables();
    t_unknown();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule